// File: doc/BRIEF.md
# Flash Erase and Program Status Controller

This block holds the write-status side of a NOR-style flash bank. It takes already-decoded commands (word program, buffered program, sector erase, chip erase, erase suspend/resume, reset and buffer-abort reset). It runs them against a small behavioural word array and produces the status byte that a host polls while an embedded operation is running. Program and erase are timed as a series of internal pulses. A pulse lasts a fixed number of clock cycles, and the number of pulses is bounded.

Sector erase is not started at once. Each sector erase command opens, or reopens, an acceptance window, and further sectors may join the erase set while that window is open. When the window closes, the erase itself runs. A program that asks a cell to go from 0 back to 1 cannot succeed. It uses up the pulse budget and then parks in a failed state until a reset arrives.

Top module: `fes_flash_status_ctrl`

## Requirements
- R1: After reset the bank is in array-read mode, `busy` is 0 and every word reads as all ones.
- R2: A sector erase command (opcode 3, sector = upper address bits) in read mode raises `busy` and opens a window of T_WIN cycles with status bit 3 at 0. If no further sector erase arrives, the erase starts T_WIN clock edges after the command and status bit 3 reads 1.
- R3: A sector erase arriving while the window is open adds its sector to the erase set and reloads the full T_WIN count.
- R4: While erasing, every command except suspend is ignored. The erase ends after ERASE_PULSES*PULSE_CYC cycles in the erase state, sets every word of the selected sectors to all ones and returns to read mode.
- R5: Chip erase (opcode 4) skips the window, enters the erase state on the next edge and selects all sectors.
- R6: Word program (opcode 1) whose data clears bits only succeeds after PULSE_CYC cycles and stores the old word ANDed with the data.
- R7: A program that needs any bit to go from 0 to 1 fails after PULSE_CYC*MAX_PULSES cycles. Status bit 5 then reads 1 and the word is unchanged. Every command except reset (opcode 6) is ignored in that failed state.
- R8: Reset after a failure returns to array read. If the failed program was issued during erase suspend, it returns to suspend-read instead.
- R9: Suspend (opcode 5) during an erase stops it: `busy` drops and array reads resume. A word program is accepted there. A second suspend resumes the erase with its remaining time.
- R10: A buffered program (opcode 2) at a word offset other than 0 within its sector aborts with status bit 1 at 1. Only buffer-abort reset (opcode 7) leaves that state. At offset 0 it behaves as a word program.
- R11: Status byte in the low 8 bits, all other bits 0: bit 7 is the inverse of data bit 7 during program, failure or abort, and 0 during window or erase; bit 6 inverts on every status read; bit 5 = failed; bit 3 = erase running; bit 1 = aborted.
- R12: A read returns data with `rd_vld` one cycle after `rd_en`. In read and suspend-read modes it returns array contents rather than status.
- R13: In read mode, suspend, reset and buffer-abort reset have no effect, and opcode 0 is no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Word address of the command |
| cmd_data | input | DW | Program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | DW | Array word or status byte |
| busy | output | 1 | Window, erase or program in progress |

## Verification
`busy` and the mode shown by status reads change on the clock edge that takes a command. Read data appears one edge after `rd_en`. Erase begins T_WIN edges after the last sector erase. A program ends PULSE_CYC edges after it starts, or PULSE_CYC*MAX_PULSES edges when it fails, and an erase ends ERASE_PULSES*PULSE_CYC edges after it begins. The bench model advances once per edge with the same inputs, applying these counts. It compares `busy`, `rd_vld` and `rd_data` at each falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_PROG       = 3'd1,
        OP_BUFPROG    = 3'd2,
        OP_SECT_ERASE = 3'd3,
        OP_CHIP_ERASE = 3'd4,
        OP_SUSPEND    = 3'd5,
        OP_RESET      = 3'd6,
        OP_ABORT_RST  = 3'd7
    } fes_op_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_WINDOW,
        ST_ERASE,
        ST_PROG,
        ST_SUSP,
        ST_FAIL,
        ST_ABORT
    } fes_state_e;

    localparam int BIT_POLL   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;
    localparam int BIT_ERASE  = 3;
    localparam int BIT_ABORT  = 1;

    function automatic logic shows_array(fes_state_e st);
        return (st == ST_READ) || (st == ST_SUSP);
    endfunction

    function automatic logic is_busy(fes_state_e st);
        return (st == ST_WINDOW) || (st == ST_ERASE) || (st == ST_PROG);
    endfunction

    function automatic logic [7:0] status_byte(fes_state_e st, logic pd7, logic tog);
        logic [7:0] s;
        s = '0;
        s[BIT_POLL]   = (st == ST_PROG || st == ST_FAIL || st == ST_ABORT) ? ~pd7 : 1'b0;
        s[BIT_TOGGLE] = tog;
        s[BIT_LIMIT]  = (st == ST_FAIL);
        s[BIT_ERASE]  = (st == ST_ERASE);
        s[BIT_ABORT]  = (st == ST_ABORT);
        return s;
    endfunction

endpackage

// File: rtl/fes_pulse.sv
module fes_pulse #(
    parameter int CYC   = 3,
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic pend,
    output logic at_limit
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam int NW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cyc_q;
    logic [NW-1:0] pul_q;

    assign pend     = run && (cyc_q == CW'(CYC - 1));
    assign at_limit = (pul_q == NW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cyc_q <= '0;
            pul_q <= '0;
        end else if (run) begin
            if (cyc_q == CW'(CYC - 1)) begin
                cyc_q <= '0;
                pul_q <= at_limit ? '0 : pul_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
        pend && at_limit |=> !at_limit || (LIMIT == 1));

endmodule

// File: rtl/fes_window.sv
module fes_window #(
    parameter int T_WIN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int WW = $clog2(T_WIN + 1);

    logic [WW-1:0] cnt_q;

    assign expire = run && !load && (cnt_q == WW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= WW'(T_WIN);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r3_window_reloads: assert property (@(posedge clk) disable iff (rst)
        load |=> !expire || (T_WIN == 1));

endmodule

// File: rtl/fes_array.sv
module fes_array #(
    parameter int N_SECT = 4,
    parameter int WPS    = 4,
    parameter int DW     = 16,
    localparam int WORDS = N_SECT * WPS,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [AW-1:0]     prog_addr,
    input  logic [DW-1:0]     prog_data,
    input  logic              erase_en,
    input  logic [N_SECT-1:0] erase_sel,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_word,
    output logic [DW-1:0]     pg_word
);
    logic [DW-1:0] mem [WORDS];

    assign rd_word = mem[rd_addr];
    assign pg_word = mem[prog_addr];

    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (rst) begin
                mem[w] <= '1;
            end else if (erase_en && erase_sel[w / WPS]) begin
                mem[w] <= '1;
            end else if (prog_en && prog_addr == AW'(w)) begin
                mem[w] <= mem[w] & prog_data;
            end
        end
    end

    a_r6_and_store: assert property (@(posedge clk) disable iff (rst)
        prog_en && !erase_en |=> mem[$past(prog_addr)] == ($past(pg_word) & $past(prog_data)));

    for (genvar s = 0; s < N_SECT; s++) begin : g_erase_chk
        a_r4_sector_ones: assert property (@(posedge clk) disable iff (rst)
            erase_en && erase_sel[s] |=> mem[s * WPS] == {DW{1'b1}});
    end

endmodule

// File: rtl/fes_flash_status_ctrl.sv
module fes_flash_status_ctrl
    import fes_pkg::*;
#(
    parameter int N_SECT       = 4,
    parameter int WPS          = 4,
    parameter int DW           = 16,
    parameter int T_WIN        = 6,
    parameter int PULSE_CYC    = 3,
    parameter int MAX_PULSES   = 4,
    parameter int ERASE_PULSES = 2,
    localparam int WORDS       = N_SECT * WPS,
    localparam int AW          = $clog2(WORDS),
    localparam int WB          = $clog2(WPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_vld,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_vld,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam int SW = AW - WB;

    fes_state_e        st_q;
    logic [N_SECT-1:0] set_q;
    logic [AW-1:0]     pa_q;
    logic [DW-1:0]     pd_q;
    logic              from_susp_q;
    logic              tgl_q;

    logic is_prog, is_buf, is_se, is_ce, is_susp, is_reset, is_abrst;
    assign is_prog  = cmd_vld && cmd_op == OP_PROG;
    assign is_buf   = cmd_vld && cmd_op == OP_BUFPROG;
    assign is_se    = cmd_vld && cmd_op == OP_SECT_ERASE;
    assign is_ce    = cmd_vld && cmd_op == OP_CHIP_ERASE;
    assign is_susp  = cmd_vld && cmd_op == OP_SUSPEND;
    assign is_reset = cmd_vld && cmd_op == OP_RESET;
    assign is_abrst = cmd_vld && cmd_op == OP_ABORT_RST;

    logic [SW-1:0]     cmd_sect;
    logic              aligned;
    logic [N_SECT-1:0] sect_bit;
    assign cmd_sect = cmd_addr[AW-1:WB];
    assign aligned  = (cmd_addr[WB-1:0] == '0);
    assign sect_bit = N_SECT'(1) << cmd_sect;

    logic start_prog;
    assign start_prog = (st_q == ST_READ && (is_prog || (is_buf && aligned)))
                     || (st_q == ST_SUSP && is_prog);

    // acceptance window
    logic win_load, win_exp;
    assign win_load = (st_q == ST_READ || st_q == ST_WINDOW) && is_se;

    fes_window #(.T_WIN(T_WIN)) u_win (
        .clk(clk), .rst(rst), .load(win_load),
        .run(st_q == ST_WINDOW), .expire(win_exp)
    );

    // erase pulse sequencer
    logic er_clr, er_run, er_pend, er_last, er_done;
    assign er_clr  = (st_q == ST_READ && is_ce) || (st_q == ST_WINDOW && !is_se && win_exp);
    assign er_run  = (st_q == ST_ERASE) && !is_susp;
    assign er_done = er_pend && er_last;

    fes_pulse #(.CYC(PULSE_CYC), .LIMIT(ERASE_PULSES)) u_er_pulse (
        .clk(clk), .rst(rst), .clr(er_clr), .run(er_run),
        .pend(er_pend), .at_limit(er_last)
    );

    // program pulse sequencer
    logic pg_pend, pg_last, pg_ok, pg_good, pg_fail;
    logic [DW-1:0] pg_word, rd_word;

    fes_pulse #(.CYC(PULSE_CYC), .LIMIT(MAX_PULSES)) u_pg_pulse (
        .clk(clk), .rst(rst), .clr(start_prog), .run(st_q == ST_PROG),
        .pend(pg_pend), .at_limit(pg_last)
    );

    assign pg_ok   = ((~pg_word & pd_q) == '0);
    assign pg_good = pg_pend && pg_ok;
    assign pg_fail = pg_pend && !pg_ok && pg_last;

    fes_array #(.N_SECT(N_SECT), .WPS(WPS), .DW(DW)) u_array (
        .clk(clk), .rst(rst),
        .prog_en(pg_good), .prog_addr(pa_q), .prog_data(pd_q),
        .erase_en(er_done), .erase_sel(set_q),
        .rd_addr(rd_addr), .rd_word(rd_word), .pg_word(pg_word)
    );

    // mode sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_READ;
            set_q       <= '0;
            pa_q        <= '0;
            pd_q        <= '0;
            from_susp_q <= 1'b0;
        end else begin
            if (start_prog) begin
                pa_q <= cmd_addr;
                pd_q <= cmd_data;
            end
            unique case (st_q)
                ST_READ: begin
                    if (start_prog) begin
                        st_q        <= ST_PROG;
                        from_susp_q <= 1'b0;
                    end else if (is_buf) begin
                        st_q <= ST_ABORT;
                        pd_q <= cmd_data;
                    end else if (is_se) begin
                        st_q  <= ST_WINDOW;
                        set_q <= sect_bit;
                    end else if (is_ce) begin
                        st_q  <= ST_ERASE;
                        set_q <= '1;
                    end
                end
                ST_WINDOW: begin
                    if (is_se)        set_q <= set_q | sect_bit;
                    else if (win_exp) st_q  <= ST_ERASE;
                end
                ST_ERASE: begin
                    if (is_susp) begin
                        st_q <= ST_SUSP;
                    end else if (er_done) begin
                        st_q  <= ST_READ;
                        set_q <= '0;
                    end
                end
                ST_SUSP: begin
                    if (is_susp) begin
                        st_q <= ST_ERASE;
                    end else if (start_prog) begin
                        st_q        <= ST_PROG;
                        from_susp_q <= 1'b1;
                    end
                end
                ST_PROG: begin
                    if (pg_good) begin
                        st_q        <= from_susp_q ? ST_SUSP : ST_READ;
                        from_susp_q <= 1'b0;
                    end else if (pg_fail) begin
                        st_q <= ST_FAIL;
                    end
                end
                ST_FAIL: begin
                    if (is_reset) begin
                        st_q        <= from_susp_q ? ST_SUSP : ST_READ;
                        from_susp_q <= 1'b0;
                    end
                end
                ST_ABORT: begin
                    if (is_abrst) st_q <= ST_READ;
                end
                default: st_q <= ST_READ;
            endcase
        end
    end

    // read port: array word or status byte
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
            tgl_q   <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) begin
                if (shows_array(st_q)) begin
                    rd_data <= rd_word;
                end else begin
                    rd_data <= DW'(status_byte(st_q, pd_q[7], tgl_q));
                    tgl_q   <= ~tgl_q;
                end
            end
        end
    end

    assign busy = is_busy(st_q);

    a_r3_window_restart: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_WINDOW && is_se |=> st_q == ST_WINDOW);
    a_r5_chip_direct: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_READ && is_ce |=> st_q == ST_ERASE && set_q == '1);
    a_r4_erase_ignores: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_ERASE && !is_susp |=> st_q == ST_ERASE || st_q == ST_READ);
    a_r7_fail_holds: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_FAIL && !is_reset |=> st_q == ST_FAIL);
    a_r8_reset_to_susp: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_FAIL && is_reset && from_susp_q |=> st_q == ST_SUSP);
    a_r10_abort_holds: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_ABORT && !is_abrst |=> st_q == ST_ABORT);
    a_r12_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);
    a_r11_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        rd_en && !shows_array(st_q) |=> rd_data[6] != tgl_q);

endmodule

// File: tb/fes_flash_status_ctrl_tb.sv
`timescale 1ns/1ps
module fes_flash_status_ctrl_tb;
    localparam int NS = 4, WP = 4, DW = 16, TW = 6, PC = 3, MP = 4, EP = 2;
    localparam int NW = NS * WP, AW = 4;

    localparam int M_READ = 0, M_WIN = 1, M_ERASE = 2, M_PROG = 3,
                   M_SUSP = 4, M_FAIL = 5, M_ABORT = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_vld = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic rd_en = 1'b0;
    logic rd_vld, busy;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    fes_flash_status_ctrl #(.N_SECT(NS), .WPS(WP), .DW(DW), .T_WIN(TW),
        .PULSE_CYC(PC), .MAX_PULSES(MP), .ERASE_PULSES(EP)) u_dut (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data), .busy(busy));

    int total = 0, bad = 0;
    logic [DW-1:0] m_mem [NW];
    int m_st, m_win, m_rem, m_pa, m_set;
    logic [DW-1:0] m_pd;
    bit m_fs, m_ok, m_tgl;
    bit e_busy, e_vld;
    logic [DW-1:0] e_data;
    string e_req = "R1";
    bit done = 0;
    int seed = 12345;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NW; i++) m_mem[i] = '1;
        m_st = M_READ; m_win = 0; m_rem = 0; m_pa = 0; m_set = 0;
        m_pd = '0; m_fs = 0; m_ok = 0; m_tgl = 0;
        e_busy = 0; e_vld = 0; e_data = '0;
    endtask

    task automatic start_program(input int a, input logic [DW-1:0] d, input bit fs);
        m_pa = a; m_pd = d; m_fs = fs;
        m_ok = ((~m_mem[a] & d) == '0);
        m_rem = m_ok ? PC : PC * MP;
        m_st = M_PROG;
    endtask

    task automatic model_step(input int op, input int a, input logic [DW-1:0] d,
                              input bit ren, input int ra);
        int sec, off;
        logic [DW-1:0] s;
        sec = a / WP; off = a % WP;
        e_vld = ren;
        if (ren) begin
            if (m_st == M_READ || m_st == M_SUSP) begin
                e_data = m_mem[ra];
            end else begin
                s = '0;
                s[7] = (m_st == M_PROG || m_st == M_FAIL || m_st == M_ABORT) ? ~m_pd[7] : 1'b0;
                s[6] = m_tgl;
                s[5] = (m_st == M_FAIL);
                s[3] = (m_st == M_ERASE);
                s[1] = (m_st == M_ABORT);
                e_data = s;
                m_tgl = ~m_tgl;
            end
        end
        case (m_st)
            M_READ: begin
                if (op == 1 || (op == 2 && off == 0)) start_program(a, d, 0);
                else if (op == 2) begin m_pd = d; m_st = M_ABORT; end
                else if (op == 3) begin m_set = 1 << sec; m_win = TW; m_st = M_WIN; end
                else if (op == 4) begin m_set = (1 << NS) - 1; m_rem = EP * PC; m_st = M_ERASE; end
            end
            M_WIN: begin
                if (op == 3) begin m_set = m_set | (1 << sec); m_win = TW; end
                else if (m_win == 1) begin m_rem = EP * PC; m_st = M_ERASE; end
                else m_win--;
            end
            M_ERASE: begin
                if (op == 5) m_st = M_SUSP;
                else if (m_rem == 1) begin
                    for (int i = 0; i < NW; i++) if (m_set[i / WP]) m_mem[i] = '1;
                    m_set = 0; m_st = M_READ;
                end else m_rem--;
            end
            M_SUSP: begin
                if (op == 5) m_st = M_ERASE;
                else if (op == 1) begin
                    int keep;
                    keep = m_rem;
                    start_program(a, d, 1);
                    m_rem = m_rem;
                    m_set = m_set;
                    m_win = keep;
                end
            end
            M_PROG: begin
                if (m_rem == 1) begin
                    if (m_ok) begin
                        m_mem[m_pa] = m_mem[m_pa] & m_pd;
                        m_st = m_fs ? M_SUSP : M_READ;
                        m_fs = 0;
                        if (m_st == M_SUSP) m_rem = m_win;
                    end else m_st = M_FAIL;
                end else m_rem--;
            end
            M_FAIL: begin
                if (op == 6) begin
                    m_st = m_fs ? M_SUSP : M_READ;
                    if (m_fs) m_rem = m_win;
                    m_fs = 0;
                end
            end
            M_ABORT: if (op == 7) m_st = M_READ;
            default: m_st = M_READ;
        endcase
        e_busy = (m_st == M_WIN || m_st == M_ERASE || m_st == M_PROG);
    endtask

    task automatic tick(input string req, input int op, input int a, input int d,
                        input bit ren, input int ra);
        @(negedge clk);
        check(e_req, "busy", busy, e_busy);
        check(e_req, "rd_vld", rd_vld, e_vld);
        if (e_vld) check(e_req, "rd_data", rd_data, e_data);
        cmd_vld = (op != 0); cmd_op = op[2:0]; cmd_addr = a[AW-1:0];
        cmd_data = d[DW-1:0]; rd_en = ren; rd_addr = ra[AW-1:0];
        e_req = req;
        model_step(op, a, d[DW-1:0], ren, ra);
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) tick(req, 0, 0, 0, 0, 0);
    endtask

    task automatic poll(input string req, input int n, input int ra);
        for (int i = 0; i < n; i++) tick(req, 0, 0, 0, 1, ra);
    endtask

    task automatic dump(input string req);
        for (int i = 0; i < NW; i++) tick(req, 0, 0, 0, 1, i);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset contents
        dump("R1");
        // R13: idle commands with no effect
        tick("R13", 5, 0, 0, 1, 0);
        tick("R13", 6, 0, 0, 1, 1);
        tick("R13", 7, 0, 0, 1, 2);
        dump("R13");
        // R6: good program, polled
        tick("R6", 1, 5, 16'hA5F0, 0, 0);
        poll("R11", 4, 5);
        dump("R6");
        // R7: 0 to 1 program fails, other commands ignored
        tick("R7", 1, 5, 16'hFFFF, 1, 5);
        poll("R7", PC * MP + 2, 5);
        tick("R7", 1, 6, 16'h0000, 1, 6);
        tick("R7", 7, 0, 0, 1, 6);
        idle("R7", PC + 1);
        poll("R7", 2, 6);
        tick("R8", 6, 0, 0, 1, 5);
        dump("R8");
        // R2/R3: windowed sector erase with an added sector
        tick("R2", 3, 4, 0, 1, 0);
        poll("R2", 3, 0);
        tick("R3", 3, 9, 0, 1, 0);
        poll("R3", TW + 2, 0);
        // R4: commands ignored while erasing
        tick("R4", 1, 0, 16'h0000, 1, 0);
        tick("R4", 6, 0, 0, 1, 0);
        poll("R4", EP * PC + 2, 0);
        dump("R4");
        // R5: chip erase after some programs
        tick("R5", 1, 1, 16'h0F0F, 0, 0); idle("R5", PC + 1);
        tick("R5", 1, 14, 16'h1234, 0, 0); idle("R5", PC + 1);
        tick("R5", 4, 0, 0, 1, 0);
        poll("R5", EP * PC + 2, 14);
        dump("R5");
        // R9: suspend, program in suspend, failure in suspend, resume
        tick("R9", 1, 3, 16'h00FF, 0, 0); idle("R9", PC + 1);
        tick("R9", 3, 0, 0, 0, 0);
        idle("R9", TW + 1);
        tick("R9", 5, 0, 0, 1, 3);
        poll("R9", 2, 3);
        tick("R9", 1, 12, 16'h7777, 1, 12);
        poll("R9", PC + 1, 12);
        tick("R8", 1, 12, 16'h8888, 0, 0);
        poll("R8", PC * MP + 1, 12);
        tick("R8", 6, 0, 0, 1, 12);
        poll("R8", 2, 12);
        tick("R9", 5, 0, 0, 1, 3);
        poll("R9", EP * PC + 2, 3);
        dump("R9");
        // R10: misaligned buffer abort, aligned buffer program
        tick("R10", 2, 9, 16'h0055, 1, 9);
        poll("R10", 3, 9);
        tick("R10", 6, 0, 0, 1, 9);
        poll("R10", 2, 9);
        tick("R10", 7, 0, 0, 1, 9);
        tick("R10", 2, 8, 16'h00AA, 1, 8);
        poll("R10", PC + 1, 8);
        dump("R10");
        // R11/R12: mixed traffic
        for (int i = 0; i < 600; i++) begin
            int op, a, d, r;
            seed = seed * 1103515245 + 12345;
            op = ((seed >>> 16) & 15);
            if (op > 7) op = 0;
            a = (seed >>> 8) & 15;
            d = (seed >>> 3) & 16'hFFFF;
            r = (seed >>> 12) & 1;
            tick((i % 2) ? "R11" : "R12", op, a, d, r, (seed >>> 20) & 15);
        end
        tick("R12", 7, 0, 0, 0, 0);
        tick("R12", 6, 0, 0, 0, 0);
        idle("R12", 40);
        tick("R12", 5, 0, 0, 0, 0);
        idle("R12", 40);
        dump("R12");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule